// File: doc/BRIEF.md
# Fixed-Point Barrel Shifter with Exponent Logic

This block is the shift unit of a 16-bit fixed-point datapath. It takes one 16-bit operand per operation and writes a 32-bit result register made of two 16-bit halves. Each operation places the operand against the upper or the lower half before shifting. It can either overwrite the result or OR into it, so two operations can assemble one 32-bit word.

Besides arithmetic and logical shifts, the unit finds exponents. It counts the redundant sign bits of an operand into a signed shift-exponent register. A following normalize operation uses that exponent. A block-exponent register tracks the largest exponent seen across a run of operands, so the whole block can be scaled with one shift.

The surrounding sequencer decodes instructions and evaluates the condition codes. It presents the operand, the operation and its options, and raises `exec_i` for one cycle when the operation is to take effect.

Top module: `dsp_shifter_unit`

## Requirements
- R1: After reset the result register reads 0, the shift exponent reads 0, and the block exponent reads -16.
- R2: No register changes while `exec_i` is low. With `exec_i` high, op codes 5 to 7 change nothing. Exponent operations (op 3, 4) leave the result register unchanged.
- R3: `ref_i` selects the placement: 0 = LO, 1 = HI, 2 = HIX, and HIX places like HI for shifts. HI puts the operand in bits 31:16 with zeros below. LO puts it in bits 15:0, with the upper half filled by copies of operand bit 15 for an arithmetic shift (op 0) and by zeros for a logical shift (op 1) or normalize (op 2).
- R4: With `or_acc_i` high, a shift or normalize ORs its value into the present result. With `or_acc_i` low, it replaces the result.
- R5: For op 0 and op 1 the signed 8-bit amount is `imm_i` when `use_imm_i` is high, and the shift exponent otherwise. A positive amount shifts left and a negative amount shifts right.
- R6: Left shifts of 32 or more give zero. Right shifts of 32 or more give all copies of the fill bit.
- R7: A right arithmetic shift fills with the sign of the placed value. A right logical shift fills with zeros.
- R8: Exponent detect (op 3) with HI, or with HIX while `av_i` is low, sets the shift exponent to minus the count of bits below bit 15 that equal bit 15 before the first that differs (range -15..0).
- R9: Exponent detect with HIX while `av_i` is high sets the shift exponent to +1.
- R10: Exponent detect with LO acts only when the shift exponent is -15. It then sets the exponent to -15 minus the count of leading operand bits equal to the sign seen by the last HI/HIX detect (range -15..-31). Otherwise the exponent is unchanged.
- R11: Normalize (op 2) shifts the placed operand by minus the shift exponent. Bits vacated by a right shift take the value of `ac_i`.
- R12: Block-exponent adjust (op 4) replaces the block exponent with the R8 exponent of the operand when that is larger. The block exponent therefore never decreases and stays in -16..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exec_i | input | 1 | Execute enable for the presented operation |
| op_i | input | 3 | 0 arith shift, 1 logical shift, 2 normalize, 3 exponent detect, 4 block-exponent adjust |
| ref_i | input | 2 | Placement: 0 LO, 1 HI, 2 HIX |
| or_acc_i | input | 1 | OR the new value into the result register |
| use_imm_i | input | 1 | Take the shift amount from imm_i instead of the shift exponent |
| imm_i | input | 8 | Signed immediate shift amount |
| operand_i | input | 16 | Operand |
| av_i | input | 1 | Operand overflowed (for HIX detect) |
| ac_i | input | 1 | Carry, shifted in by a right normalize |
| sr_o | output | 32 | Result register |
| se_o | output | 8 | Shift exponent, signed |
| sb_o | output | 5 | Block exponent, signed |

## Verification
The hardest state to reach is the low-half exponent extension. It needs a HI detect that finds a fully redundant upper word (exponent exactly -15) directly before a LO detect. The sign seen by that HI detect must also match the LO word's leading bits. Directed pairs with both all-zero and all-one upper words reach this state, and so does a LO detect issued while the exponent is not -15. A long random stream then mixes in operands drawn mostly from 0x0000 and 0xFFFF, so such pairs recur, while a behavioural model is compared on every clock.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [2:0] {
    OP_ASHIFT = 3'd0,
    OP_LSHIFT = 3'd1,
    OP_NORM   = 3'd2,
    OP_EXP    = 3'd3,
    OP_EXPADJ = 3'd4
  } shf_op_e;

  typedef enum logic [1:0] {
    REF_LO  = 2'd0,
    REF_HI  = 2'd1,
    REF_HIX = 2'd2
  } shf_ref_e;
endpackage

// File: rtl/shf_position.sv
module shf_position #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0]   val_i,
  input  logic                hi_i,
  input  logic                ext_i,
  output logic [2*DATA_W-1:0] pos_o
);
  always_comb begin
    if (hi_i) pos_o = {val_i, {DATA_W{1'b0}}};
    else      pos_o = {{DATA_W{ext_i}}, val_i};
  end
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
  parameter int RES_W = 32,
  parameter int AMT_W = 8
) (
  input  logic [RES_W-1:0] val_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             fill_i,
  output logic [RES_W-1:0] res_o
);
  localparam int LOG_W = $clog2(RES_W);

  logic             neg;
  logic [AMT_W:0]   amt_ext;
  logic [AMT_W:0]   mag;
  logic             big;
  logic [RES_W-1:0] lft [LOG_W+1];
  logic [RES_W-1:0] rgt [LOG_W+1];

  assign neg     = amt_i[AMT_W-1];
  assign amt_ext = {amt_i[AMT_W-1], amt_i};
  assign mag     = neg ? (~amt_ext + 1'b1) : amt_ext;
  assign big     = (mag >= (AMT_W+1)'(RES_W));

  assign lft[0] = val_i;
  assign rgt[0] = val_i;

  for (genvar k = 0; k < LOG_W; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign lft[k+1] = mag[k] ? {lft[k][RES_W-SH-1:0], {SH{1'b0}}} : lft[k];
    assign rgt[k+1] = mag[k] ? {{SH{fill_i}}, rgt[k][RES_W-1:SH]} : rgt[k];
  end

  always_comb begin
    if (neg) res_o = big ? {RES_W{fill_i}} : rgt[LOG_W];
    else     res_o = big ? '0 : lft[LOG_W];
  end
endmodule

// File: rtl/shf_lead_cnt.sv
module shf_lead_cnt #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic              ref_i,
  output logic [CNT_W-1:0]  cnt_o
);
  logic run;
  always_comb begin
    cnt_o = '0;
    run   = 1'b1;
    for (int i = DATA_W-1; i >= 0; i--) begin
      if (run && (val_i[i] == ref_i)) cnt_o = cnt_o + 1'b1;
      else                            run   = 1'b0;
    end
  end
endmodule

// File: rtl/dsp_shifter_unit.sv
module dsp_shifter_unit
  import shf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AMT_W  = 8,
  parameter int BEXP_W = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                exec_i,
  input  logic [2:0]          op_i,
  input  logic [1:0]          ref_i,
  input  logic                or_acc_i,
  input  logic                use_imm_i,
  input  logic [AMT_W-1:0]    imm_i,
  input  logic [DATA_W-1:0]   operand_i,
  input  logic                av_i,
  input  logic                ac_i,
  output logic [2*DATA_W-1:0] sr_o,
  output logic [AMT_W-1:0]    se_o,
  output logic [BEXP_W-1:0]   sb_o
);
  localparam int RES_W   = 2*DATA_W;
  localparam int CNT_W   = $clog2(DATA_W+1);
  localparam int RED_MAX = DATA_W-1;

  shf_op_e  op;
  shf_ref_e rsel;
  assign op   = shf_op_e'(op_i);
  assign rsel = shf_ref_e'(ref_i);

  logic [RES_W-1:0]  sr_q, pos, shifted;
  logic [AMT_W-1:0]  se_q, amt;
  logic [BEXP_W-1:0] sb_q;
  logic              hi_sign_q;
  logic              ext_bit, fill_bit, is_shift;
  logic [CNT_W-1:0]  cnt_self, cnt_lo;
  logic [AMT_W-1:0]  exp_hi, exp_lo;
  logic [BEXP_W-1:0] exp_blk;

  assign is_shift = (op == OP_ASHIFT) || (op == OP_LSHIFT) || (op == OP_NORM);
  assign ext_bit  = (op == OP_ASHIFT) & operand_i[DATA_W-1];

  shf_position #(.DATA_W(DATA_W)) u_pos (
    .val_i(operand_i),
    .hi_i (rsel != REF_LO),
    .ext_i(ext_bit),
    .pos_o(pos)
  );

  always_comb begin
    if (op == OP_NORM)  amt = AMT_W'(0) - se_q;
    else if (use_imm_i) amt = imm_i;
    else                amt = se_q;
    case (op)
      OP_ASHIFT: fill_bit = pos[RES_W-1];
      OP_NORM:   fill_bit = ac_i;
      default:   fill_bit = 1'b0;
    endcase
  end

  shf_barrel #(.RES_W(RES_W), .AMT_W(AMT_W)) u_barrel (
    .val_i (pos),
    .amt_i (amt),
    .fill_i(fill_bit),
    .res_o (shifted)
  );

  shf_lead_cnt #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt_self (
    .val_i(operand_i),
    .ref_i(operand_i[DATA_W-1]),
    .cnt_o(cnt_self)
  );

  shf_lead_cnt #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt_lo (
    .val_i(operand_i),
    .ref_i(hi_sign_q),
    .cnt_o(cnt_lo)
  );

  // cnt_self includes the sign bit itself
  assign exp_hi  = AMT_W'(1) - AMT_W'(cnt_self);
  assign exp_lo  = AMT_W'(0) - AMT_W'(RED_MAX) - AMT_W'(cnt_lo);
  assign exp_blk = BEXP_W'(exp_hi);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q      <= '0;
      se_q      <= '0;
      sb_q      <= BEXP_W'(-DATA_W);
      hi_sign_q <= 1'b0;
    end else if (exec_i) begin
      if (is_shift) begin
        sr_q <= or_acc_i ? (sr_q | shifted) : shifted;
      end else if (op == OP_EXP) begin
        if (rsel == REF_HIX && av_i) begin
          se_q <= AMT_W'(1);
        end else if (rsel == REF_HI || rsel == REF_HIX) begin
          se_q      <= exp_hi;
          hi_sign_q <= operand_i[DATA_W-1];
        end else if (rsel == REF_LO && se_q == AMT_W'(-RED_MAX)) begin
          se_q <= exp_lo;
        end
      end else if (op == OP_EXPADJ) begin
        if ($signed(exp_blk) > $signed(sb_q)) sb_q <= exp_blk;
      end
    end
  end

  assign sr_o = sr_q;
  assign se_o = se_q;
  assign sb_o = sb_q;
endmodule

// File: rtl/dsp_shifter_unit_chk.sv
module dsp_shifter_unit_chk #(
  parameter int DATA_W = 16,
  parameter int AMT_W  = 8,
  parameter int BEXP_W = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                exec_i,
  input logic [2:0]          op_i,
  input logic [1:0]          ref_i,
  input logic                or_acc_i,
  input logic                av_i,
  input logic [2*DATA_W-1:0] sr_o,
  input logic [AMT_W-1:0]    se_o,
  input logic [BEXP_W-1:0]   sb_o
);
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> ($stable(sr_o) && $stable(se_o) && $stable(sb_o))); // R2

  AST_SR_KEEP_EXP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && (op_i == 3'd3 || op_i == 3'd4)) |=> $stable(sr_o)); // R2

  AST_OR_KEEPS_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op_i <= 3'd2 && or_acc_i) |=> ((sr_o & $past(sr_o)) == $past(sr_o))); // R4

  AST_EXP_HI_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op_i == 3'd3 && ref_i == 2'd1)
      |=> ($signed(se_o) <= 0 && $signed(se_o) >= -(DATA_W-1))); // R8

  AST_HIX_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op_i == 3'd3 && ref_i == 2'd2 && av_i) |=> (se_o == AMT_W'(1))); // R9

  AST_SB_MONOTONIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op_i == 3'd4) |=> ($signed(sb_o) >= $signed($past(sb_o)))); // R12

  AST_SB_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($signed(sb_o) <= 0 && $signed(sb_o) >= -DATA_W)); // R12
endmodule

bind dsp_shifter_unit dsp_shifter_unit_chk #(
  .DATA_W(DATA_W), .AMT_W(AMT_W), .BEXP_W(BEXP_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .exec_i(exec_i), .op_i(op_i), .ref_i(ref_i),
  .or_acc_i(or_acc_i), .av_i(av_i), .sr_o(sr_o), .se_o(se_o), .sb_o(sb_o)
);

// File: tb/dsp_shifter_unit_bench.sv
`timescale 1ns/1ps
module dsp_shifter_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  rsel = '0;
  logic        orr = 1'b0, ui = 1'b0, av = 1'b0, ac = 1'b0;
  logic [7:0]  imm = '0;
  logic [15:0] x = '0;
  logic [31:0] sr;
  logic [7:0]  se;
  logic [4:0]  sb;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";

  // reference state
  logic [31:0] m_sr = '0;
  int          m_se = 0, m_sb = -16;
  bit          m_hs = 0;

  always #4 clk = ~clk;

  dsp_shifter_unit u_dsp_shifter_unit (
    .clk_i(clk), .rst_ni(rst_n), .exec_i(exec), .op_i(op), .ref_i(rsel),
    .or_acc_i(orr), .use_imm_i(ui), .imm_i(imm), .operand_i(x),
    .av_i(av), .ac_i(ac), .sr_o(sr), .se_o(se), .sb_o(sb)
  );

  function automatic int redund(logic [15:0] v);
    int c = 0;
    for (int i = 14; i >= 0; i--) begin
      if (v[i] != v[15]) break;
      c++;
    end
    return c;
  endfunction

  function automatic int lead_eq(logic [15:0] v, bit b);
    int c = 0;
    for (int i = 15; i >= 0; i--) begin
      if (v[i] != b) break;
      c++;
    end
    return c;
  endfunction

  function automatic logic [31:0] ref_shift(logic [31:0] p, int n, bit f);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      if (n >= 0) r[i] = (i - n >= 0) ? p[i-n] : 1'b0;
      else        r[i] = (i - n <= 31) ? p[i-n] : f;
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sr = '0; m_se = 0; m_sb = -16; m_hs = 0;
    end else if (exec) begin
      if (op <= 3'd2) begin
        logic [31:0] p, r;
        int n;
        bit f;
        if (rsel != 2'd0) p = {x, 16'h0};
        else p = {((op == 3'd0) ? {16{x[15]}} : 16'h0), x};
        if (op == 3'd2) n = -m_se;
        else n = ui ? int'($signed(imm)) : m_se;
        f = (op == 3'd0) ? p[31] : (op == 3'd2) ? ac : 1'b0;
        r = ref_shift(p, n, f);
        m_sr = orr ? (m_sr | r) : r;
      end else if (op == 3'd3) begin
        if (rsel == 2'd2 && av) m_se = 1;
        else if (rsel != 2'd0) begin m_se = -redund(x); m_hs = x[15]; end
        else if (m_se == -15) m_se = -15 - lead_eq(x, m_hs);
      end else if (op == 3'd4) begin
        if (-redund(x) > m_sb) m_sb = -redund(x);
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks += 3;
      if (sr !== m_sr) begin errors++; $display("FAIL %s sr actual %h expected %h", tag, sr, m_sr); end
      if (int'($signed(se)) != m_se) begin errors++; $display("FAIL %s se actual %0d expected %0d", tag, $signed(se), m_se); end
      if (int'($signed(sb)) != m_sb) begin errors++; $display("FAIL %s sb actual %0d expected %0d", tag, $signed(sb), m_sb); end
    end
  end

  task automatic chk(string t, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual %0d (%h) expected %0d (%h)", t, act, act, expv, expv);
    end
  endtask

  task automatic do_op(string t, bit e, int o, int r, bit oa, bit u, int im,
                       logic [15:0] v, bit a = 0, bit c = 0);
    @(negedge clk);
    tag = t; exec = e; op = 3'(o); rsel = 2'(r); orr = oa; ui = u;
    imm = 8'(im); x = v; av = a; ac = c;
    @(negedge clk);
    exec = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sr", int'(sr), 0);
    chk("R1 se", int'($signed(se)), 0);
    chk("R1 sb", int'($signed(sb)), -16);

    do_op("R3", 1, 1, 1, 0, 1, 0, 16'h8001);
    chk("R3 HI place", int'(sr), int'(32'h80010000));
    do_op("R3", 1, 0, 0, 0, 1, 0, 16'h8001);
    chk("R3 LO arith", int'(sr), int'(32'hFFFF8001));
    do_op("R3", 1, 1, 0, 0, 1, 0, 16'h8001);
    chk("R3 LO logic", int'(sr), int'(32'h00008001));
    do_op("R4", 1, 1, 1, 0, 1, 0, 16'h1234);
    do_op("R4", 1, 1, 0, 1, 1, 0, 16'h5678);
    chk("R4 or build", int'(sr), int'(32'h12345678));
    do_op("R2", 0, 0, 1, 0, 1, 3, 16'hFFFF);
    chk("R2 exec low", int'(sr), int'(32'h12345678));
    do_op("R2", 1, 7, 1, 0, 1, 3, 16'hFFFF);
    chk("R2 bad op", int'(sr), int'(32'h12345678));
    do_op("R4", 1, 0, 0, 0, 1, 4, 16'h0001);
    chk("R4 overwrite", int'(sr), 32'h10);
    do_op("R7", 1, 0, 1, 0, 1, -4, 16'h8000);
    chk("R7 arith right", int'(sr), int'(32'hF8000000));
    do_op("R7", 1, 1, 1, 0, 1, -4, 16'h8000);
    chk("R7 logic right", int'(sr), int'(32'h08000000));
    do_op("R5", 1, 0, 1, 0, 1, 1, 16'h4000);
    chk("R5 left", int'(sr), int'(32'h80000000));
    do_op("R6", 1, 1, 0, 0, 1, 32, 16'hFFFF);
    chk("R6 left 32", int'(sr), 0);
    do_op("R6", 1, 0, 1, 0, 1, -40, 16'h8000);
    chk("R6 arith right 40", int'(sr), -1);
    do_op("R6", 1, 1, 1, 0, 1, -32, 16'h8000);
    chk("R6 logic right 32", int'(sr), 0);
    do_op("R8", 1, 3, 1, 0, 0, 0, 16'h0010);
    chk("R8 exp", int'($signed(se)), -10);
    do_op("R5", 1, 0, 1, 0, 0, 0, 16'h0010);
    chk("R5 by se", int'(sr), int'(32'h00000400));
    do_op("R11", 1, 2, 1, 0, 0, 0, 16'h0010);
    chk("R11 norm", int'(sr), int'(32'h40000000));
    do_op("R9", 1, 3, 2, 0, 0, 0, 16'h7000, 1);
    chk("R9 hix", int'($signed(se)), 1);
    do_op("R11", 1, 2, 1, 0, 0, 0, 16'h7000, 0, 1);
    chk("R11 carry in", int'(sr), int'(32'hB8000000));
    do_op("R10", 1, 3, 1, 0, 0, 0, 16'h0000);
    chk("R10 hi zero", int'($signed(se)), -15);
    do_op("R10", 1, 3, 0, 0, 0, 0, 16'h00FF);
    chk("R10 lo ext", int'($signed(se)), -23);
    do_op("R10", 1, 3, 0, 0, 0, 0, 16'h0001);
    chk("R10 lo hold", int'($signed(se)), -23);
    do_op("R10", 1, 3, 1, 0, 0, 0, 16'hFFFF);
    do_op("R10", 1, 3, 0, 0, 0, 0, 16'hF000);
    chk("R10 lo ones", int'($signed(se)), -19);
    do_op("R12", 1, 4, 0, 0, 0, 0, 16'h0100);
    chk("R12 first", int'($signed(sb)), -6);
    do_op("R12", 1, 4, 0, 0, 0, 0, 16'h0FFF);
    chk("R12 rise", int'($signed(sb)), -3);
    do_op("R12", 1, 4, 0, 0, 0, 0, 16'h00FF);
    chk("R12 keep", int'($signed(sb)), -3);
    do_op("R12", 1, 4, 0, 0, 0, 0, 16'hC000);
    chk("R12 top", int'($signed(sb)), -1);

    for (int i = 0; i < 3000; i++) begin
      int k = int'($urandom_range(0, 3));
      logic [15:0] v = (k == 0) ? 16'h0000 : (k == 1) ? 16'hFFFF : 16'($urandom);
      if (k == 3) v = v >> $urandom_range(0, 15);
      do_op("R5", ($urandom_range(0, 7) != 0), int'($urandom_range(0, 7)),
            int'($urandom_range(0, 2)), 1'($urandom), 1'($urandom),
            int'($urandom_range(0, 255)), v, 1'($urandom), 1'($urandom));
    end

    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule